// File: doc/BRIEF.md
# Cartridge RAM Mapper with Split Read and Write Ports

This block is the controller of a cartridge that plugs into a CPU bus with no read/write strobe. It answers a 4K address window, selected when address bit 12 is high. The first page of that window is taken over by a 128-byte RAM with two address ranges. The lower half of the page is a write port and the upper half is a read port. Every other offset in the window returns a byte from a fixed internal ROM, whose contents are computed and not stored.

The cartridge cannot see which way a cycle goes, so it treats any cycle that lands in the write range as a write. The byte it stores is whatever sits on the data bus at that moment. When the CPU drives the bus, that is the CPU's data. When nobody drives it, the bus still holds its last value, which is usually a ROM byte the cartridge drove one cycle earlier. This matters for indexed reads. If the base address is in the read port and the index carries into the next page, the CPU first puts out an address whose high byte is not yet adjusted. That address hits the write port and silently corrupts one RAM entry. The block reproduces this case exactly.

Each clock edge ends one bus cycle. The address decode and the read data are combinational within the cycle. RAM writes and the bus keeper update at the edge. The bus is modelled as two separate sides. The cartridge drives `data_o` and `data_oe_o`. The other side is given by `data_i` and `cpu_drv_i`, which together say what value the CPU places on the bus, if any. The resolved bus value is not a port.

Top module: `cart_ram_mapper`

## Requirements
- R1: When address bit 12 is low, `data_oe_o` is 0 and no RAM entry changes.
- R2: At window offsets 0x100 to 0xFFF, `data_oe_o` is 1 and `data_o` equals 0xA5 ^ off[7:0] ^ {off[11:8], off[11:8]}, where off is address bits 11:0.
- R3: At window offsets 0x080 to 0x0FF (the read port), `data_oe_o` is 1 and `data_o` is RAM entry off[6:0].
- R4: At window offsets 0x000 to 0x07F (the write port), `data_oe_o` is 0, whether or not the cycle is really a read.
- R5: In a write-port cycle with `cpu_drv_i` high, `data_i` is stored into RAM entry off[6:0] at the end of the cycle.
- R6: In a write-port cycle with `cpu_drv_i` low, the stored byte is the bus keeper value, which is the last byte anyone drove.
- R7: The bus keeper takes the resolved bus value in every cycle where someone drives the bus. The resolved value is `data_i` if `cpu_drv_i` is high, otherwise `data_o` if `data_oe_o` is high. In cycles where nobody drives, the keeper holds its value.
- R8: After reset every RAM entry and the bus keeper read as 0x00.
- R9: A page-crossing dummy access into the write port, right after a ROM read, replaces the addressed entry with that ROM byte.
- R10: A read-port cycle never changes the RAM, even when `cpu_drv_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus cycle clock; each rising edge ends a cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 13 | CPU address bus |
| data_i | input | 8 | Value the CPU places on the data bus |
| cpu_drv_i | input | 1 | High when the CPU side drives the data bus this cycle |
| data_o | output | 8 | Byte the cartridge drives onto the bus |
| data_oe_o | output | 1 | Cartridge drive enable |

## Verification
Some rules are checked by assertions on every cycle:
- the drive enable follows the decoded region (R1, R3, R4);
- each write-port cycle leaves the stored byte in the addressed entry (R5, R6);
- the keeper holds its value whenever nobody drives (R7).

Other behaviour needs the bench's scenarios, which track RAM and keeper contents over many cycles:
- the exact ROM values;
- what a dummy access actually stores;
- that read-port cycles with a CPU drive leave the RAM untouched;
- the page-crossing corruption sequence.

// File: rtl/cart_pkg.sv
package cart_pkg;
  typedef enum logic [1:0] {
    RGN_NONE   = 2'd0,
    RGN_RAM_WR = 2'd1,
    RGN_RAM_RD = 2'd2,
    RGN_ROM    = 2'd3
  } region_e;
endpackage

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
  import cart_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int OFF_W  = 12,
  parameter int RAM_AW = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam int PageLsb = RAM_AW + 1;

  logic win_sel;
  logic first_page;

  assign win_sel    = addr_i[ADDR_W-1];
  assign off_o      = addr_i[OFF_W-1:0];
  assign first_page = (off_o[OFF_W-1:PageLsb] == '0);

  always_comb begin
    region_o = RGN_NONE;
    if (win_sel) begin
      if (!first_page)          region_o = RGN_ROM;
      else if (off_o[RAM_AW])   region_o = RGN_RAM_RD;
      else                      region_o = RGN_RAM_WR;
    end
  end
endmodule

// File: rtl/cart_rom.sv
module cart_rom #(
  parameter int          OFF_W  = 12,
  parameter int          DATA_W = 8,
  parameter logic [7:0]  SEED   = 8'hA5
) (
  input  logic [OFF_W-1:0]  off_i,
  output logic [DATA_W-1:0] data_o
);
  // Contents are a fold of the offset; no stored array.
  function automatic logic [DATA_W-1:0] rom_byte(input logic [OFF_W-1:0] off);
    logic [OFF_W-1:0]  hi;
    logic [DATA_W-1:0] h;
    hi = off >> DATA_W;
    h  = hi[DATA_W-1:0];
    return DATA_W'(SEED) ^ off[DATA_W-1:0] ^ h ^ (h << (DATA_W / 2));
  endfunction

  assign data_o = rom_byte(off_i);
endmodule

// File: rtl/cart_ram.sv
module cart_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  AST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i)); // R5 R6
endmodule

// File: rtl/cart_bus_keeper.sv
module cart_bus_keeper #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_drv_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic              cart_oe_i,
  input  logic [DATA_W-1:0] cart_data_i,
  output logic [DATA_W-1:0] bus_o
);
  logic [DATA_W-1:0] keep_q;

  // CPU side wins a contention; otherwise the bus holds its last value.
  always_comb begin
    if (cpu_drv_i)      bus_o = cpu_data_i;
    else if (cart_oe_i) bus_o = cart_data_i;
    else                bus_o = keep_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) keep_q <= '0;
    else         keep_q <= bus_o;
  end

  AST_KEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_drv_i && !cart_oe_i) |=> $stable(keep_q)); // R7
  AST_KEEP_CART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_drv_i && cart_oe_i) |=> keep_q == $past(cart_data_i)); // R7
endmodule

// File: rtl/cart_ram_mapper.sv
module cart_ram_mapper
  import cart_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int RAM_DEPTH = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cpu_drv_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int OFF_W  = ADDR_W - 1;
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  region_e           region;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] rom_data;
  logic [DATA_W-1:0] ram_rdata;
  logic [DATA_W-1:0] bus_val;
  logic              ram_we;

  cart_addr_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .RAM_AW(RAM_AW)) u_dec (
    .addr_i  (addr_i),
    .region_o(region),
    .off_o   (off)
  );

  cart_rom #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_rom (
    .off_i (off),
    .data_o(rom_data)
  );

  // No read/write strobe: every write-port cycle is a write.
  assign ram_we = (region == RGN_RAM_WR);

  cart_ram #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ram_we),
    .waddr_i(off[RAM_AW-1:0]),
    .wdata_i(bus_val),
    .raddr_i(off[RAM_AW-1:0]),
    .rdata_o(ram_rdata)
  );

  always_comb begin
    data_oe_o = 1'b0;
    data_o    = '0;
    unique case (region)
      RGN_ROM:    begin data_oe_o = 1'b1; data_o = rom_data;  end
      RGN_RAM_RD: begin data_oe_o = 1'b1; data_o = ram_rdata; end
      default:    ;
    endcase
  end

  cart_bus_keeper #(.DATA_W(DATA_W)) u_keep (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_drv_i  (cpu_drv_i),
    .cpu_data_i (data_i),
    .cart_oe_i  (data_oe_o),
    .cart_data_i(data_o),
    .bus_o      (bus_val)
  );

  AST_OUTSIDE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[ADDR_W-1] |-> !data_oe_o); // R1
  AST_WR_PORT_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1] && addr_i[OFF_W-1:RAM_AW] == '0) |-> !data_oe_o); // R4
  AST_RD_PORT_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1] && addr_i[OFF_W-1:RAM_AW+1] == '0 && addr_i[RAM_AW])
      |-> (data_oe_o && data_o == ram_rdata)); // R3
  AST_OUTSIDE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[ADDR_W-1] |-> !ram_we); // R1
endmodule

// File: tb/tb_cart_ram_mapper.sv
module tb_cart_ram_mapper;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic        drv = 0;
  logic [7:0]  dout;
  logic        oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_ram [128];
  logic [7:0] m_keep;

  always #5 clk = ~clk;

  cart_ram_mapper dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din),
    .cpu_drv_i(drv), .data_o(dout), .data_oe_o(oe)
  );

  function automatic logic [7:0] exp_rom(input logic [11:0] off);
    return 8'hA5 ^ off[7:0] ^ {off[11:8], off[11:8]};
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle: drive after negedge, check mid-cycle, commit model at posedge.
  task automatic bus(input logic [12:0] a, input logic d_on, input logic [7:0] d);
    logic       e_oe;
    logic [7:0] e_do;
    logic [7:0] busv;
    logic [11:0] off;
    string req;
    @(negedge clk);
    addr = a; drv = d_on; din = d;
    off = a[11:0];
    e_oe = 0; e_do = 8'h00;
    if (!a[12])                  req = "R1";
    else if (off >= 12'h100) begin req = "R2"; e_oe = 1; e_do = exp_rom(off); end
    else if (off[7])         begin req = "R3"; e_oe = 1; e_do = m_ram[off[6:0]]; end
    else                         req = "R4";
    #2;
    chk(req, {oe, oe ? dout : 8'h00}, {e_oe, e_do});
    busv = d_on ? d : (e_oe ? e_do : m_keep);
    @(posedge clk);
    if (a[12] && off < 12'h080) m_ram[off[6:0]] = busv;
    m_keep = busv;
  endtask

  task automatic peek(input logic [6:0] idx, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = {1'b1, 12'h080 | {5'd0, idx}}; drv = 0;
    #2;
    chk(req, {oe, dout}, {1'b1, exp});
    @(posedge clk);
    m_keep = exp;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) m_ram[i] = 8'h00;
    m_keep = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R8: reset contents
    peek(7'd0, 8'h00, "R8");
    peek(7'd127, 8'h00, "R8");
    // R6 R8: undriven write right after reset stores keeper (read of 0 above) -> 0
    bus(13'h1010, 0, 8'hEE);
    peek(7'h10, 8'h00, "R6");
    // R5: real CPU write
    bus(13'h1003, 1, 8'h3C);
    peek(7'h03, 8'h3C, "R5");
    // R9: ROM read then page-crossing dummy access into write port
    bus(13'h1123, 0, 8'h00);
    bus(13'h1005, 0, 8'h77);
    peek(7'h05, exp_rom(12'h123), "R9");
    // R7: cart-driven read-port byte becomes keeper, then dummy write copies it
    bus(13'h1083, 0, 8'h00);
    bus(13'h1040, 0, 8'h00);
    peek(7'h40, 8'h3C, "R7");
    // R10: CPU drive during read port does not write
    bus(13'h1083, 1, 8'h99);
    peek(7'h03, 8'h3C, "R10");
    // R1: outside window, CPU drives an address that aliases write port
    bus(13'h0003, 1, 8'h11);
    peek(7'h03, 8'h3C, "R1");
    // R2: ROM boundary offsets
    bus(13'h1100, 0, 8'h00);
    bus(13'h1FFF, 0, 8'h00);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [12:0] a;
      int sel;
      sel = $urandom_range(0, 3);
      case (sel)
        0: a = {1'b0, 12'($urandom)};
        1: a = {1'b1, 5'd0, 7'($urandom)};
        2: a = {1'b1, 5'd1, 7'($urandom)};
        default: a = {1'b1, 12'h100 | 12'($urandom)};
      endcase
      bus(a, 1'($urandom), 8'($urandom));
    end
    for (int i = 0; i < 128; i++) peek(7'(i), m_ram[i], "R5");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule